// File: doc/BRIEF.md
# PHY Update Handshake Arbiter

This block answers update requests raised by the physical layer of a DRAM controller. When the PHY raises its update request together with a 2-bit type code, the block immediately tells the command scheduler to hold off all new read, write and control traffic. It then waits until every command already committed and every read or write data window already in flight has finished. Only then does it raise acknowledge. The acknowledge therefore means the interface is idle and will stay that way.

The block keeps acknowledge high, and traffic blocked, until the PHY withdraws its request. It then drops acknowledge and releases the scheduler one cycle later. A request is never refused.

While acknowledge is high, a watchdog compares how long the PHY keeps the request up with a programmable maximum. The maximum is chosen from a four-entry table by the type code captured when the request was accepted. If the hold runs too long, a sticky timeout flag is set.

Top module: `phyupd_arbiter`

## Requirements
- R1: After reset, `upd_ack`, `traffic_hold` and `upd_timeout` are all low.
- R2: `traffic_hold` is high in the same cycle that `upd_req` is first seen high while the block is idle. It stays high in every cycle in which `upd_req` is high.
- R3: `upd_ack` rises one clock after the first cycle, following acceptance, in which `rd_busy`, `wr_busy` and `cmd_pend` are all low. It never rises when any of them was high in the previous cycle. With all three low, `upd_ack` is therefore high two cycles after the request cycle.
- R4: Once high, `upd_ack` stays high in every cycle that follows a cycle with `upd_req` high. `traffic_hold` is high whenever `upd_ack` is high.
- R5: `upd_ack` goes low in the cycle after the first cycle in which it is high and `upd_req` is low.
- R6: `traffic_hold` stays high in the cycle after `upd_ack` falls. It is low in the cycle after that, unless a new request is present.
- R7: The type code is captured in the cycle the request is accepted. Later changes on `upd_type` have no effect on the timeout limit.
- R8: `dur_table` holds one DUR_W-bit limit per type, with entry i in bits [i*DUR_W +: DUR_W]. Number the acknowledge cycles from 0, starting with the first cycle in which `upd_ack` is high, and let L be the selected limit. `upd_timeout` rises in the cycle after acknowledge cycle L if `upd_req` is still high in cycle L. If the request falls at or before cycle L, the flag does not rise.
- R9: `upd_timeout` is sticky: once set, it stays high until reset, across later requests.
- R10: A new request that arrives right after a release is handled with the same timing as the first, without a reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_req | input | 1 | Update request from the PHY |
| upd_type | input | TYPE_W | Update type code from the PHY |
| cmd_pend | input | 1 | Scheduler has a committed command that has not yet reached the bus |
| rd_busy | input | 1 | A read data window is in flight |
| wr_busy | input | 1 | A write data window is in flight |
| dur_table | input | NUM_TYPES*DUR_W | Maximum acknowledge hold time per type |
| upd_ack | output | 1 | Update acknowledge to the PHY |
| traffic_hold | output | 1 | Blocks new scheduler traffic |
| upd_timeout | output | 1 | Sticky flag: the request was held past its limit |

## Verification
The assertions rely on the PHY keeping its request high until it has seen acknowledge. They also rely on the busy and pending inputs eventually going low once traffic is blocked. No input is assumed to stay stable within a cycle of the type code after acceptance, because the bench deliberately disturbs that code.

The stimulus respects these assumptions by construction. It raises the request from idle and holds it through the drain phase and for a chosen number of acknowledge cycles before dropping it. The busy indications are driven high only for a bounded number of cycles, starting at the request.

// File: rtl/phyupd_pkg.sv
package phyupd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BLOCK   = 2'd1,
    ST_ACK     = 2'd2,
    ST_RELEASE = 2'd3
  } upd_state_e;

  // Interface is quiet once nothing is committed or in flight.
  function automatic logic bus_drained(input logic pend, input logic rd, input logic wr);
    return !(pend || rd || wr);
  endfunction
endpackage

// File: rtl/phyupd_fsm.sv
module phyupd_fsm
  import phyupd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       drained,
  output upd_state_e state,
  output logic       accept,
  output logic       ack,
  output logic       hold
);
  upd_state_e nxt;

  assign accept = (state == ST_IDLE) && req;
  assign ack    = (state == ST_ACK);
  assign hold   = (state != ST_IDLE) || req;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (req) nxt = ST_BLOCK;
      ST_BLOCK:   if (drained) nxt = ST_ACK;
      ST_ACK:     if (!req) nxt = ST_RELEASE;
      ST_RELEASE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/phyupd_type_sel.sv
module phyupd_type_sel #(
  parameter int TYPE_W    = 2,
  parameter int DUR_W     = 16,
  localparam int NUM_TYPES = 1 << TYPE_W
) (
  input  logic [NUM_TYPES*DUR_W-1:0] table_flat,
  input  logic [TYPE_W-1:0]          sel,
  output logic [DUR_W-1:0]           limit
);
  logic [DUR_W-1:0] entry [NUM_TYPES];

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_unpack
    assign entry[g] = table_flat[g*DUR_W +: DUR_W];
  end

  assign limit = entry[sel];
endmodule

// File: rtl/phyupd_wdog.sv
module phyupd_wdog #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_ack,
  input  logic             req,
  input  logic [DUR_W-1:0] limit,
  output logic             limit_hit,
  output logic             timeout
);
  logic [DUR_W-1:0] cnt;

  // Acknowledge cycle index cnt has reached the programmed bound.
  function automatic logic reached(input logic [DUR_W-1:0] c, input logic [DUR_W-1:0] l);
    return c >= l;
  endfunction

  assign limit_hit = in_ack && req && reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      if (!in_ack)          cnt <= '0;
      else if (cnt < limit) cnt <= cnt + 1'b1;
      if (limit_hit)        timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/phyupd_arbiter.sv
module phyupd_arbiter
  import phyupd_pkg::*;
#(
  parameter int TYPE_W    = 2,
  parameter int DUR_W     = 16,
  localparam int NUM_TYPES = 1 << TYPE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_req,
  input  logic [TYPE_W-1:0]          upd_type,
  input  logic                       cmd_pend,
  input  logic                       rd_busy,
  input  logic                       wr_busy,
  input  logic [NUM_TYPES*DUR_W-1:0] dur_table,
  output logic                       upd_ack,
  output logic                       traffic_hold,
  output logic                       upd_timeout
);
  upd_state_e       state;
  logic             accept;
  logic             drained;
  logic             in_ack;
  logic             limit_hit;
  logic [TYPE_W-1:0] type_q;
  logic [DUR_W-1:0]  limit;

  assign drained = bus_drained(cmd_pend, rd_busy, wr_busy);

  phyupd_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (upd_req),
    .drained (drained),
    .state   (state),
    .accept  (accept),
    .ack     (in_ack),
    .hold    (traffic_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      type_q <= '0;
    else if (accept) type_q <= upd_type;
  end

  phyupd_type_sel #(.TYPE_W(TYPE_W), .DUR_W(DUR_W)) u_sel (
    .table_flat (dur_table),
    .sel        (type_q),
    .limit      (limit)
  );

  phyupd_wdog #(.DUR_W(DUR_W)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ack    (in_ack),
    .req       (upd_req),
    .limit     (limit),
    .limit_hit (limit_hit),
    .timeout   (upd_timeout)
  );

  assign upd_ack = in_ack;
endmodule

// File: rtl/phyupd_arbiter_chk.sv
module phyupd_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic upd_req,
  input logic cmd_pend,
  input logic rd_busy,
  input logic wr_busy,
  input logic upd_ack,
  input logic traffic_hold,
  input logic upd_timeout,
  input logic accept,
  input logic limit_hit
);
  p_hold_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> traffic_hold);

  p_hold_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> traffic_hold);

  p_ack_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ack) |-> $past(!cmd_pend && !rd_busy && !wr_busy));

  p_ack_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack && upd_req |=> upd_ack);

  p_ack_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack |-> traffic_hold);

  p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ack && !upd_req |=> !upd_ack);

  p_release_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_ack) |-> traffic_hold);

  p_release_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_ack) |=> (!traffic_hold || upd_req));

  p_timeout_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> upd_timeout);

  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_timeout |=> upd_timeout);
endmodule

bind phyupd_arbiter phyupd_arbiter_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_req      (upd_req),
  .cmd_pend     (cmd_pend),
  .rd_busy      (rd_busy),
  .wr_busy      (wr_busy),
  .upd_ack      (upd_ack),
  .traffic_hold (traffic_hold),
  .upd_timeout  (upd_timeout),
  .accept       (accept),
  .limit_hit    (limit_hit)
);

// File: tb/test_phyupd_arbiter.sv
module test_phyupd_arbiter;
  localparam int TYPE_W = 2;
  localparam int DUR_W  = 16;
  localparam int NT     = 1 << TYPE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_req = 1'b0;
  logic [TYPE_W-1:0] upd_type = '0;
  logic cmd_pend = 1'b0, rd_busy = 1'b0, wr_busy = 1'b0;
  logic [NT*DUR_W-1:0] dur_table;
  logic upd_ack, traffic_hold, upd_timeout;

  int n_run = 0;
  int n_bad = 0;
  int wd = 0;
  bit sticky = 1'b0;
  int lims [NT] = '{3, 1, 4, 2};

  always #2 clk = ~clk;

  phyupd_arbiter #(.TYPE_W(TYPE_W), .DUR_W(DUR_W)) i_phyupd_arbiter (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_type(upd_type),
    .cmd_pend(cmd_pend), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .dur_table(dur_table), .upd_ack(upd_ack), .traffic_hold(traffic_hold),
    .upd_timeout(upd_timeout)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int cyc);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_req = 1'b0; cmd_pend = 1'b0; rd_busy = 1'b0; wr_busy = 1'b0;
    #1;
    chk("R1 ack", upd_ack, 1'b0, -1);
    chk("R1 hold", traffic_hold, 1'b0, -1);
    chk("R1 timeout", upd_timeout, 1'b0, -1);
    @(negedge clk);
    rst_n = 1'b1;
    sticky = 1'b0;
  endtask

  // ty: type; b: busy cycles from request; src: which busy input; h: ack cycles with req high
  task automatic run_upd(input int ty, input int b, input int src, input int h);
    int a, lim, drop;
    bit to;
    a    = 1 + ((b > 1) ? b : 1);
    lim  = lims[ty];
    drop = a + h;
    to   = (h > lim);
    for (int n = 0; n <= drop + 2; n++) begin
      @(negedge clk);
      upd_req  = (n < drop);
      upd_type = (n == 0) ? TYPE_W'(ty) : ~TYPE_W'(ty);   // R7 disturbance
      cmd_pend = (src == 0) && (n < b);
      rd_busy  = (src == 1) && (n < b);
      wr_busy  = (src == 2) && (n < b);
      #1;
      chk(n < a ? "R3 ack wait" : (n <= drop ? "R4 ack hold" : "R5 ack drop"),
          upd_ack, (n >= a) && (n <= drop), n);
      chk(n <= drop ? "R2 hold" : "R6 hold release", traffic_hold, n <= drop + 1, n);
      chk(sticky ? "R9 sticky" : "R8 R7 timeout", upd_timeout,
          sticky || (to && n >= a + lim + 1), n);
    end
    sticky = sticky || to;
  endtask

  initial begin
    for (int i = 0; i < NT; i++) dur_table[i*DUR_W +: DUR_W] = DUR_W'(lims[i]);
    do_reset();
    for (int ty = 0; ty < NT; ty++)
      for (int b = 0; b < 4; b++)
        for (int dh = -1; dh <= 1; dh++) begin
          if (lims[ty] + dh >= 0) begin
            do_reset();
            run_upd(ty, b, (ty + b) % 3, lims[ty] + dh);
          end
        end
    // R10: back-to-back requests with no reset; R9 sticky carried across
    do_reset();
    run_upd(1, 0, 0, 0);
    run_upd(2, 2, 1, 5);
    run_upd(0, 3, 2, 1);
    run_upd(3, 1, 0, 2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule